// File: doc/BRIEF.md
# UART Baud Tick Generator with High-Speed Codes

This block produces the clock enables that pace a 16550-style serial port. A 16-bit divisor sits in two byte-wide latches, each written separately and read back through a byte multiplexer. The block emits a 16x oversampling tick and a 1x bit tick derived from it. The system clock is taken to run at `REF_MULT` times the nominal reference rate of 1.8432 MHz. At the default of 4 this is 7.3728 MHz, so one reference period lasts four system cycles.

In normal operation a divisor `D` gives one 16x tick every `D` reference periods, which is `D*REF_MULT` system cycles. A divisor of 1 therefore gives 115200 baud. A configuration input `hsEn`, held outside the divisor latches, enables two special codes. With `hsEn` high, 0x8002 selects 230400 baud and 0x8001 selects 460800 baud. With `hsEn` low, both codes are ordinary large divisors. A divisor of zero stops both ticks. The receiver can restart the bit-tick phase so that it lines up with a start-bit edge.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both divisor bytes read 0 and neither tick is asserted.
- R2: For a nonzero divisor D that is not a high-speed code in effect, `tick16` is a one-cycle pulse every D*REF_MULT clock cycles (for example D=2304 gives 9216 and D=6 gives 24).
- R3: With `hsEn`=1, divisor 0x8002 (32770) gives a `tick16` period of REF_MULT/2 cycles (2 at the default), which is 230400 baud.
- R4: With `hsEn`=1, divisor 0x8001 (32769) gives a `tick16` period of REF_MULT/4 cycles (1 at the default, so a tick on every cycle), which is 460800 baud.
- R5: With `hsEn`=0, the codes 0x8001 and 0x8002 are ordinary divisors, so no `tick16` appears within a few hundred cycles of loading them.
- R6: A divisor of 0 holds `tick16` and `tick1` low for as long as it remains loaded.
- R7: A write to either divisor byte, or a change of `hsEn`, reloads the counter at that clock edge. The first `tick16` then comes exactly one new period after that edge.
- R8: `tick1` is asserted only together with `tick16`, on every 16th `tick16`.
- R9: A one-cycle `phaseClr` pulse restarts both counters. The first `tick1` follows 16 periods after the clearing edge.
- R10: `rdData` shows the low divisor byte when `rdSelHi`=0 and the high byte when `rdSelHi`=1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, REF_MULT times the reference rate |
| rstN | input | 1 | Active-low synchronous reset |
| dllWe | input | 1 | Write strobe, low divisor byte |
| dlmWe | input | 1 | Write strobe, high divisor byte |
| wrData | input | 8 | Byte written into the selected latch |
| rdSelHi | input | 1 | Read select: 0 low byte, 1 high byte |
| rdData | output | 8 | Selected divisor byte |
| hsEn | input | 1 | High-speed code enable (configuration bit) |
| phaseClr | input | 1 | Restart pulse for 16x and bit-tick phase |
| tick16 | output | 1 | 16x oversampling enable |
| tick1 | output | 1 | 1x bit enable |

## Verification
A reload at clock edge k loads period-1 into the down-counter. `tick16` is therefore visible after edge k+P-1 and then every P cycles, with P cycles counted from k. The bench drives inputs on falling edges and counts falling edges from the one after the reload edge, so for period P the tick is expected at count P. The second interval is measured the same way. `tick1` after a phase clear is expected at count 16P. Read-back is combinational and is sampled in the same low phase in which the select changes.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Strobes from the control half to the counting datapath
  typedef struct packed {
    logic reload;  // restart both counters from the supplied reload value
    logic run;     // divisor currently loaded is nonzero
  } baud_strobe_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int REF_MULT   = 4,
  parameter bit HS_SUPPORT = 1'b1,
  parameter int CNT_W      = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dllWe,
  input  logic              dlmWe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdSelHi,
  output logic [BYTE_W-1:0] rdData,
  input  logic              hsEn,
  input  logic              phaseClr,
  output baud_strobe_t      strobe,
  output logic [CNT_W-1:0]  periodM1
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam logic [DIV_W-1:0] HS_CODE_4X = {1'b1, {(DIV_W-3){1'b0}}, 2'b01};
  localparam logic [DIV_W-1:0] HS_CODE_2X = {1'b1, {(DIV_W-3){1'b0}}, 2'b10};

  logic [BYTE_W-1:0] lowQ, highQ;
  logic              hsPrev;
  logic [DIV_W-1:0]  curDiv, nextDiv;
  logic [CNT_W-1:0]  plainM1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ   <= '0;
      highQ  <= '0;
      hsPrev <= 1'b0;
    end else begin
      if (dllWe) lowQ  <= wrData;
      if (dlmWe) highQ <= wrData;
      hsPrev <= hsEn;
    end
  end

  assign curDiv  = {highQ, lowQ};
  // divisor as it will stand after this edge
  assign nextDiv = {dlmWe ? wrData : highQ, dllWe ? wrData : lowQ};
  assign rdData  = rdSelHi ? highQ : lowQ;

  always_comb begin
    if (nextDiv == '0) plainM1 = '0;
    else               plainM1 = CNT_W'(nextDiv) * CNT_W'(REF_MULT) - CNT_W'(1);
  end

  generate
    if (HS_SUPPORT) begin : g_hs
      always_comb begin
        if (hsEn && nextDiv == HS_CODE_4X)      periodM1 = CNT_W'(REF_MULT / 4 - 1);
        else if (hsEn && nextDiv == HS_CODE_2X) periodM1 = CNT_W'(REF_MULT / 2 - 1);
        else                                    periodM1 = plainM1;
      end
    end else begin : g_plain
      assign periodM1 = plainM1;
    end
  endgenerate

  always_comb begin
    strobe.reload = dllWe | dlmWe | phaseClr | (hsEn != hsPrev);
    strobe.run    = (curDiv != '0);
  end

  // R10: a byte just written to the low latch is visible on the read path
  p_readback_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dllWe) && !dlmWe && !dllWe && !rdSelHi) |-> (rdData == $past(wrData)));
endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pkg::*;
#(
  parameter int CNT_W      = 18,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  baud_strobe_t     strobe,
  input  logic [CNT_W-1:0] periodM1,
  output logic             tick16,
  output logic             tick1
);
  localparam int PH_W = $clog2(OVERSAMPLE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  phase;

  assign tick16 = strobe.run && (cnt == '0);
  assign tick1  = tick16 && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= '0;
    end else if (strobe.reload) begin
      cnt   <= periodM1;
      phase <= '0;
    end else if (strobe.run) begin
      if (cnt == '0) begin
        cnt   <= periodM1;
        phase <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R2: between ticks the counter steps down by one each cycle
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.reload && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R7: after a reload with a period above one cycle, no tick in the next cycle
  p_reload_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && periodM1 != '0) |=> !tick16);
  // R8: bit ticks never come back to back
  p_bit_spacing_r8: assert property (@(posedge clk) disable iff (!rstN)
    tick1 |=> !tick1);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int REF_MULT   = 4,
  parameter bit HS_SUPPORT = 1'b1,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dllWe,
  input  logic              dlmWe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdSelHi,
  output logic [BYTE_W-1:0] rdData,
  input  logic              hsEn,
  input  logic              phaseClr,
  output logic              tick16,
  output logic              tick1
);
  localparam int CNT_W = 2 * BYTE_W + $clog2(REF_MULT);

  baud_strobe_t     strobe;
  logic [CNT_W-1:0] periodM1;

  baud_ctrl #(.BYTE_W(BYTE_W), .REF_MULT(REF_MULT), .HS_SUPPORT(HS_SUPPORT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dllWe(dllWe), .dlmWe(dlmWe), .wrData(wrData),
    .rdSelHi(rdSelHi), .rdData(rdData), .hsEn(hsEn), .phaseClr(phaseClr),
    .strobe(strobe), .periodM1(periodM1)
  );

  baud_dp #(.CNT_W(CNT_W), .OVERSAMPLE(OVERSAMPLE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodM1(periodM1),
    .tick16(tick16), .tick1(tick1)
  );

  // R4: with the fastest code settled and high-speed on, every cycle ticks
  p_hs_fast_r4: assert property (@(posedge clk) disable iff (!rstN)
    (HS_SUPPORT && hsEn && $past(hsEn) && !$past(dllWe) && !$past(dlmWe) && !$past(phaseClr)
     && {u_ctrl.highQ, u_ctrl.lowQ} == {1'b1, {(2*BYTE_W-3){1'b0}}, 2'b01}
     && $past({u_ctrl.highQ, u_ctrl.lowQ}) == {1'b1, {(2*BYTE_W-3){1'b0}}, 2'b01})
    |-> tick16);
  // R6: a zero divisor that stays loaded keeps both outputs quiet
  p_zero_halt_r6: assert property (@(posedge clk) disable iff (!rstN)
    ({u_ctrl.highQ, u_ctrl.lowQ} == '0) |-> (!tick16 && !tick1));
endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  localparam int REF_MULT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dllWe = 1'b0, dlmWe = 1'b0, rdSelHi = 1'b0, hsEn = 1'b0, phaseClr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic tick16, tick1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rstN(rstN), .dllWe(dllWe), .dlmWe(dlmWe), .wrData(wrData),
    .rdSelHi(rdSelHi), .rdData(rdData), .hsEn(hsEn), .phaseClr(phaseClr),
    .tick16(tick16), .tick1(tick1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // high byte then low byte; returns at the falling edge after the final write edge
  task automatic writeDiv(input logic [15:0] d);
    @(negedge clk); dlmWe = 1'b1; wrData = d[15:8];
    @(negedge clk); dlmWe = 1'b0; dllWe = 1'b1; wrData = d[7:0];
    @(negedge clk); dllWe = 1'b0;
  endtask

  // counts falling edges starting at 1 until tick16 is seen or lim is reached
  task automatic waitTick(input int lim, output int n);
    n = 1;
    while (!tick16 && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(input logic [15:0] d, input int expP, input string req);
    int n;
    writeDiv(d);
    waitTick(expP + 20, n);
    check(n == expP, req, n, expP);
    @(negedge clk);
    waitTick(expP + 20, n);
    check(n == expP, req, n, expP);
  endtask

  initial begin
    #(190000 * 10);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n;
    int cyc;
    int t16;
    bit seen;
    int divs [10] = '{2304, 1536, 1047, 857, 768, 384, 96, 48, 12, 6};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(tick16 == 1'b0 && tick1 == 1'b0, "R1 ticks", int'(tick16), 0);
    rdSelHi = 1'b0; #1;
    check(rdData == 8'h00, "R1 low byte", rdData, 0);
    rdSelHi = 1'b1; #1;
    check(rdData == 8'h00, "R1 high byte", rdData, 0);
    rdSelHi = 1'b0;

    // R2: standard divisors
    foreach (divs[i]) measure(16'(divs[i]), divs[i] * REF_MULT, "R2 period");
    measure(16'd1, REF_MULT, "R2 period div1");

    // R10: read-back of both bytes
    writeDiv(16'h1234);
    rdSelHi = 1'b0; #1;
    check(rdData == 8'h34, "R10 low byte", rdData, 8'h34);
    rdSelHi = 1'b1; #1;
    check(rdData == 8'h12, "R10 high byte", rdData, 8'h12);
    rdSelHi = 1'b0;

    // R7: mid-count rewrite takes effect at once
    writeDiv(16'd1000);
    repeat (100) @(negedge clk);
    measure(16'd3, 3 * REF_MULT, "R7 immediate reload");

    // R6: zero divisor halts
    writeDiv(16'd0);
    seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (tick16 || tick1) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R6 zero halt", int'(seen), 0);

    // R5: special codes ordinary without high-speed
    hsEn = 1'b0;
    writeDiv(16'h8002);
    waitTick(300, n);
    check(n == 300 && !tick16, "R5 0x8002 ordinary", n, 300);
    // R7: turning high-speed on reloads immediately (period 2)
    @(negedge clk); hsEn = 1'b1;
    @(negedge clk);
    waitTick(50, n);
    check(n == REF_MULT / 2, "R7 hsEn change reload", n, REF_MULT / 2);

    // R3 and R4: high-speed codes
    measure(16'h8002, REF_MULT / 2, "R3 230400");
    measure(16'h8001, REF_MULT / 4, "R4 460800");
    hsEn = 1'b0;
    writeDiv(16'h8001);
    @(negedge clk);
    waitTick(300, n);
    check(n == 300 && !tick16, "R5 0x8001 ordinary", n, 300);

    // R9 and R8: bit tick phase
    writeDiv(16'd1);
    repeat (7) @(negedge clk);
    phaseClr = 1'b1;
    @(negedge clk); phaseClr = 1'b0;
    cyc = 1;
    while (!tick1 && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 16 * REF_MULT, "R9 first bit tick", cyc, 16 * REF_MULT);
    check(tick16 == 1'b1, "R8 bit tick with 16x tick", int'(tick16), 1);
    cyc = 0; t16 = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (tick16) t16++;
    end while (!tick1 && cyc < 1000);
    check(cyc == 16 * REF_MULT, "R8 bit period", cyc, 16 * REF_MULT);
    check(t16 == 16, "R8 ticks per bit", t16, 16);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule